// File: doc/BRIEF.md
# Link Polling Exit Qualifier

This block sits beside the training state machine of a multi-lane serial link and decides when the link may leave its active polling phase. It decides between moving on to configuration and falling back to receiver detection. An entry pulse starts a decision window. At that moment the block latches which lanes found a receiver. It then watches, for each lane, the training sets received, the non-training blocks that break a run of sets, and the electrical-idle exits. It also counts the type 1 training sets the local transmitter sends, and it counts a timeout in ticks of a clock enable.

There are two ways out. On the normal path, every receiver-detected lane must hold a run of consecutive training sets, and enough sets must have been sent. Once the timeout expires, a relaxed path opens. On that path one good lane is enough, provided that every lane in a software-chosen set saw the line leave electrical idle. With that set narrowed to one lane, a single damaged lane cannot stop the link from coming up. When all lanes work, the normal path still trains them all. The chosen outcome is held until the next entry pulse.

Top module: `poll_exit_qual`

## Requirements
- R1: While a window is open, `go_cfg` rises one clock after the registered state shows both of these: at least TX_MIN `tx_ts1` strobes since entry, and a full count of CONSEC on every receiver-detected lane. The detected mask must also be nonzero. This normal path wins over the timeout in the same clock.
- R2: Each lane's run counter adds one per clock on `ts_rx_vld[i]` and stops at CONSEC. A type 1 set and a type 2 set count alike, so the set type has no input.
- R3: `other_blk[i]` clears lane i's run counter to zero. In a clock that carries both strobes, it wins over `ts_rx_vld[i]`.
- R4: The timeout expires once TIMEOUT_TICKS clocks with `tick` high have passed since entry. The decision it enables is taken on the next clock.
- R5: After the timeout, `go_cfg` rises when three things hold. At least one detected lane has a full run. At least TX_MIN `tx_ts1` strobes arrived in clocks after the one in which any detected lane first received a set. Every lane in `pred_mask & detected` has seen `ei_exit` since entry.
- R6: After the timeout, if the conditions of R5 are not met, `go_det` rises instead.
- R7: `go_cfg` and `go_det` are never high together, and once raised they hold until the next `enter`. An `enter` closes any result, so both outputs are low one clock later, and it clears all counters, flags and the timer.
- R8: The receiver-detected mask is latched at `enter`. Lanes outside it have no effect on any per-lane condition.
- R9: After reset, both outputs are low and no window is open until `enter`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enter | input | 1 | Pulse marking entry into active polling |
| rx_det | input | LANES | Lanes that found a receiver, latched at enter |
| pred_mask | input | LANES | Lanes that must show an idle exit for the timeout path |
| ts_rx_vld | input | LANES | Per-lane strobe: a training set of either type was received |
| other_blk | input | LANES | Per-lane strobe: a non-training block was received |
| ei_exit | input | LANES | Per-lane electrical-idle exit indication |
| tx_ts1 | input | 1 | Strobe per type 1 training set transmitted |
| tick | input | 1 | Clock enable for the timeout count |
| go_cfg | output | 1 | Advance to configuration, held until enter |
| go_det | output | 1 | Return to detect, held until enter, only after the timeout |

## Verification
Some properties are checked by assertions on every cycle. The outputs never conflict and stay held until the next entry. A run counter never passes CONSEC, and it reads zero after a non-training block. A detect outcome always follows an expired timeout. Entry clears both outputs.

Other behaviour needs the bench's scenarios. These include the exact clock in which the timeout is reached and a transmit count that starts only after the first received set. They also include the predetermined set choosing between configuration and detect when a lane is broken, and lanes outside the detected mask being ignored. The bench shows these by running a reference model in step with the design.

// File: rtl/poll_exit_qual.sv
module poll_exit_qual #(
  parameter int LANES         = 4,
  parameter int TX_MIN        = 1024,
  parameter int CONSEC        = 8,
  parameter int TIMEOUT_TICKS = 24000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter,
  input  logic [LANES-1:0] rx_det,
  input  logic [LANES-1:0] pred_mask,
  input  logic [LANES-1:0] ts_rx_vld,
  input  logic [LANES-1:0] other_blk,
  input  logic [LANES-1:0] ei_exit,
  input  logic             tx_ts1,
  input  logic             tick,
  output logic             go_cfg,
  output logic             go_det
);
  localparam int CW = $clog2(CONSEC + 1);
  localparam int TW = $clog2(TX_MIN + 1);
  localparam int MW = $clog2(TIMEOUT_TICKS + 1);

  logic             active;
  logic [LANES-1:0] det_q;
  logic [LANES-1:0] ei_seen;
  logic [LANES-1:0] lane_ok;
  logic [CW-1:0]    run_cnt [LANES];
  logic [TW-1:0]    tx_all;
  logic [TW-1:0]    tx_aft;
  logic             rx_any;
  logic [MW-1:0]    tmr;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        run_cnt[i] <= '0;
      else if (enter)
        run_cnt[i] <= '0;
      else if (active) begin
        if (other_blk[i])
          run_cnt[i] <= '0;
        else if (ts_rx_vld[i] && !lane_ok[i])
          run_cnt[i] <= run_cnt[i] + 1'b1;
      end
    end
    assign lane_ok[i] = (run_cnt[i] == CW'(CONSEC));

    a_r2_run_sat: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt[i] <= CW'(CONSEC));
    a_r3_blk_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !enter && other_blk[i]) |=> (run_cnt[i] == '0));
  end

  wire tx_done   = (tx_all == TW'(TX_MIN));
  wire aft_done  = (tx_aft == TW'(TX_MIN));
  wire timed_out = (tmr == MW'(TIMEOUT_TICKS));
  wire all_ok    = &(lane_ok | ~det_q);
  wire one_ok    = |(lane_ok & det_q);
  wire ei_ok     = &(ei_seen | ~(pred_mask & det_q));
  wire norm_ok   = tx_done && all_ok && (det_q != '0);
  wire fb_ok     = aft_done && one_ok && ei_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      go_cfg  <= 1'b0;
      go_det  <= 1'b0;
      det_q   <= '0;
      ei_seen <= '0;
      tx_all  <= '0;
      tx_aft  <= '0;
      rx_any  <= 1'b0;
      tmr     <= '0;
    end else if (enter) begin
      active  <= 1'b1;
      go_cfg  <= 1'b0;
      go_det  <= 1'b0;
      det_q   <= rx_det;
      ei_seen <= '0;
      tx_all  <= '0;
      tx_aft  <= '0;
      rx_any  <= 1'b0;
      tmr     <= '0;
    end else if (active) begin
      ei_seen <= ei_seen | ei_exit;
      if (tx_ts1 && !tx_done)
        tx_all <= tx_all + 1'b1;
      if (tx_ts1 && rx_any && !aft_done)
        tx_aft <= tx_aft + 1'b1;
      if (|(ts_rx_vld & det_q))
        rx_any <= 1'b1;
      if (tick && !timed_out)
        tmr <= tmr + 1'b1;
      if (norm_ok) begin
        go_cfg <= 1'b1;
        active <= 1'b0;
      end else if (timed_out) begin
        active <= 1'b0;
        if (fb_ok) go_cfg <= 1'b1;
        else       go_det <= 1'b1;
      end
    end
  end

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_cfg && go_det));
  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (go_cfg && !enter) |=> go_cfg);
  a_r7_det_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (go_det && !enter) |=> go_det);
  a_r7_enter_clears: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (!go_cfg && !go_det));
  a_r6_det_after_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_det) |-> $past(timed_out));
  a_r1_cfg_needs_tx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_cfg) |-> $past(tx_done || aft_done));
endmodule

// File: tb/poll_exit_qual_bench.sv
module poll_exit_qual_bench;
  localparam int L = 4, TXM = 16, CONS = 8, TO = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enter = 1'b0, tx_ts1 = 1'b0, tick = 1'b0;
  logic [L-1:0] rx_det = '0, pred_mask = '0, ts_rx_vld = '0, other_blk = '0, ei_exit = '0;
  logic go_cfg, go_det;

  poll_exit_qual #(.LANES(L), .TX_MIN(TXM), .CONSEC(CONS), .TIMEOUT_TICKS(TO)) u_poll_exit_qual (
    .clk(clk), .rst_n(rst_n), .enter(enter), .rx_det(rx_det), .pred_mask(pred_mask),
    .ts_rx_vld(ts_rx_vld), .other_blk(other_blk), .ei_exit(ei_exit),
    .tx_ts1(tx_ts1), .tick(tick), .go_cfg(go_cfg), .go_det(go_det));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  bit m_act = 0, m_cfg = 0, m_det = 0, m_rxany = 0;
  bit [L-1:0] m_dq = '0, m_ei = '0;
  int m_cnt [L];
  int m_tx = 0, m_txa = 0, m_tm = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_norm();
    bit all = 1;
    for (int i = 0; i < L; i++) if (m_dq[i] && m_cnt[i] != CONS) all = 0;
    return (m_tx >= TXM) && all && (m_dq != '0);
  endfunction

  function automatic bit exp_fb();
    bit one = 0, eiok = 1;
    for (int i = 0; i < L; i++) begin
      if (m_dq[i] && m_cnt[i] == CONS) one = 1;
      if (pred_mask[i] && m_dq[i] && !m_ei[i]) eiok = 0;
    end
    return (m_txa >= TXM) && one && eiok;
  endfunction

  task automatic model_step();
    bit nrm, fb, to, rxa;
    if (enter) begin
      m_act = 1; m_cfg = 0; m_det = 0; m_dq = rx_det; m_ei = '0;
      m_tx = 0; m_txa = 0; m_rxany = 0; m_tm = 0;
      for (int i = 0; i < L; i++) m_cnt[i] = 0;
    end else if (m_act) begin
      nrm = exp_norm(); fb = exp_fb(); to = (m_tm >= TO); rxa = m_rxany;
      m_ei = m_ei | ei_exit;
      if (tx_ts1 && m_tx < TXM) m_tx++;
      if (tx_ts1 && rxa && m_txa < TXM) m_txa++;
      if ((ts_rx_vld & m_dq) != '0) m_rxany = 1;
      if (tick && m_tm < TO) m_tm++;
      for (int i = 0; i < L; i++)
        if (other_blk[i]) m_cnt[i] = 0;
        else if (ts_rx_vld[i] && m_cnt[i] < CONS) m_cnt[i]++;
      if (nrm) begin m_cfg = 1; m_act = 0; end
      else if (to) begin m_act = 0; if (fb) m_cfg = 1; else m_det = 1; end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(go_cfg == m_cfg, "R1 R5 go_cfg vs model", go_cfg, m_cfg);
    chk(go_det == m_det, "R4 R6 go_det vs model", go_det, m_det);
  endtask

  task automatic drive(bit [L-1:0] v, bit [L-1:0] o, bit [L-1:0] e, bit t, bit k);
    ts_rx_vld = v; other_blk = o; ei_exit = e; tx_ts1 = t; tick = k;
    cyc();
  endtask

  task automatic start(bit [L-1:0] det, bit [L-1:0] pm);
    rx_det = det; pred_mask = pm; enter = 1'b1;
    drive('0, '0, '0, 1'b0, 1'b0);
    enter = 1'b0; rx_det = '0;
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    for (int i = 0; i < L; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    chk(go_cfg == 0 && go_det == 0, "R9 reset outputs", {go_cfg, go_det}, 0);
    rst_n = 1'b1;
    repeat (3) drive('1, '0, '1, 1'b1, 1'b1);
    chk(go_cfg == 0 && go_det == 0, "R9 idle before enter", {go_cfg, go_det}, 0);

    start(4'b1111, 4'b0001);
    repeat (16) drive(4'b1111, '0, '0, 1'b1, 1'b1);
    chk(go_cfg == 0, "R1 one clock before decision", go_cfg, 0);
    drive('0, '0, '0, 1'b0, 1'b1);
    chk(go_cfg == 1, "R1 normal path all lanes", go_cfg, 1);

    start(4'b1111, 4'b0001);
    repeat (40) drive(4'b0001, '0, 4'b0001, 1'b1, 1'b1);
    chk(go_cfg == 0, "R4 no decision before timeout", go_cfg, 0);
    drive('0, '0, '0, 1'b0, 1'b0);
    chk(go_cfg == 1 && go_det == 0, "R5 fallback with one lane", go_cfg, 1);

    start(4'b1111, 4'b1111);
    repeat (40) drive(4'b0001, '0, 4'b0001, 1'b1, 1'b1);
    chk(go_det == 0, "R4 timeout edge not reached", go_det, 0);
    drive('0, '0, '0, 1'b0, 1'b0);
    chk(go_det == 1 && go_cfg == 0, "R6 wider pred set blocks fallback", go_det, 1);

    start(4'b0001, 4'b0001);
    repeat (16) drive('0, '0, '0, 1'b1, 1'b0);
    repeat (7) drive(4'b0001, '0, '0, 1'b0, 1'b0);
    drive(4'b0001, 4'b0001, '0, 1'b0, 1'b0);
    repeat (7) drive(4'b0001, '0, '0, 1'b0, 1'b0);
    repeat (2) drive('0, '0, '0, 1'b0, 1'b0);
    chk(go_cfg == 0, "R3 block clears run", go_cfg, 0);
    drive(4'b0001, '0, '0, 1'b0, 1'b0);
    drive('0, '0, '0, 1'b0, 1'b0);
    chk(go_cfg == 1, "R2 run reaches full count", go_cfg, 1);

    start(4'b0011, 4'b1111);
    repeat (16) drive(4'b0011, 4'b1100, 4'b0011, 1'b1, 1'b0);
    drive('0, 4'b1100, '0, 1'b0, 1'b0);
    chk(go_cfg == 1, "R8 undetected lanes ignored", go_cfg, 1);
    repeat (5) drive('1, '1, '1, 1'b1, 1'b1);
    chk(go_cfg == 1 && go_det == 0, "R7 held until entry", go_cfg, 1);
    start(4'b0011, 4'b0001);
    chk(go_cfg == 0 && go_det == 0, "R7 entry clears outputs", {go_cfg, go_det}, 0);

    for (int r = 0; r < 60; r++) begin
      bit [L-1:0] det, broken;
      det = L'($urandom) | L'(1 << ($urandom % L));
      broken = L'($urandom) & L'($urandom);
      start(det, L'($urandom));
      for (int c = 0; c < 200 && !(m_cfg || m_det); c++) begin
        bit [L-1:0] v, o;
        v = L'($urandom) | L'($urandom);
        v = v & ~broken;
        o = L'($urandom) & L'($urandom) & L'($urandom) & L'($urandom);
        drive(v, o, L'($urandom) & L'($urandom), 1'($urandom), 1'($urandom));
      end
      repeat (3) drive(L'($urandom), L'($urandom), L'($urandom), 1'($urandom), 1'($urandom));
      chk(m_cfg || m_det, "R6 random run decided", {m_cfg, m_det}, 1);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule